// File: doc/BRIEF.md
# Word-Write Byte-Read Memory

This block is a simple dual-port on-chip memory on a single clock. One port writes whole 32-bit words at a word address. The other port reads single bytes at a byte address. Depth comes from one parameter, the width of the byte read address. The write word address is two bits narrower than the byte read address.

The read address is captured on the clock edge. The addressed byte is then selected out of the stored word combinationally, with no second output register. A read therefore returns its byte in the cycle that follows the address edge. A word written on the same edge as the read address is captured is seen at once, so the read port behaves write-first.

The storage is one array of full words. The byte lane is picked straight from the word that the array returns, with no extra pipeline stage for the lane choice. The code is plain behavioural logic that any synthesis flow can map.

Top module: `awrp_ram`

## Requirements
- R1: When `wr_en` is high at a rising clock edge (with `rst_n` high), `wr_data` is stored as the word at `wr_addr`, which is `ADDR_W-2` bits wide.
- R2: `rd_data` is one byte of the word selected by `rd_addr[ADDR_W-1:2]`. The lane number is `rd_addr[1:0]`, with lane 0 at bits 7:0, lane 1 at 15:8, lane 2 at 23:16 and lane 3 at 31:24.
- R3: `rd_addr` is captured at the rising edge. A change of `rd_addr` between edges leaves `rd_data` unchanged until the next edge.
- R4: `rd_data` has no output register. If a write changes the word under the held read address, the new byte shows in the cycle right after that write edge.
- R5: Suppose the read address for a word is captured on the same edge that writes that word. The following cycle then shows the newly written byte (write-first).
- R6: With `wr_en` low, `wr_addr` and `wr_data` change no stored word.
- R7: While `rst_n` is low, the captured read address is held at 0, so `rd_data` shows lane 0 of word 0. Writes are ignored while `rst_n` is low.
- R8: The memory holds `2**ADDR_W` bytes in `2**(ADDR_W-2)` words. Every word and every lane is addressed independently, with no aliasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset for the read address register |
| wr_en | input | 1 | Write enable for the word port |
| wr_addr | input | ADDR_W-2 | Word address of the write |
| wr_data | input | 32 | Word written |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 8 | Byte read, combinational from the captured read address |

## Verification
The bench fills every word and then reads every byte address. A lane order swapped, or an address bit dropped, would surface as wrong or aliased bytes somewhere in that sweep. It changes `rd_addr` in mid-cycle to catch a read path that was left combinational from the pin. It writes to the word under a held read address to catch a stray output register, which would give the old byte one cycle late. It captures the read address on the very edge of a write to catch a read-first array, which would return the stale byte. It also checks that writes are dropped under reset and while `wr_en` is low.

// File: rtl/awrp_pkg.sv
package awrp_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/awrp_addr_reg.sv
module awrp_addr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/awrp_store.sv
module awrp_store
  import awrp_pkg::*;
#(
  parameter int WA_W = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [WA_W-1:0] waddr,
  input  word_t           wdata,
  input  logic [WA_W-1:0] raddr,
  output word_t           rword
);
  localparam int DEPTH = 1 << WA_W;

  word_t mem [DEPTH];

  // the array itself is the write data register
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/awrp_lane_sel.sv
module awrp_lane_sel
  import awrp_pkg::*;
(
  input  word_t             word,
  input  logic [LANE_W-1:0] lane,
  output byte_t             out
);
  byte_t lane_v [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_v[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign out = lane_v[lane];
endmodule

// File: rtl/awrp_ram.sv
module awrp_ram
  import awrp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-3:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int WA_W = ADDR_W - LANE_W;

  logic [ADDR_W-1:0] raddr_q;
  logic              wr_go;
  word_t             rword;

  assign wr_go = wr_en & rst_n;

  awrp_addr_reg #(.W(ADDR_W)) u_rareg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (rd_addr),
    .q     (raddr_q)
  );

  awrp_store #(.WA_W(WA_W)) u_store (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (raddr_q[ADDR_W-1:LANE_W]),
    .rword (rword)
  );

  awrp_lane_sel u_lsel (
    .word (rword),
    .lane (raddr_q[LANE_W-1:0]),
    .out  (rd_data)
  );
endmodule

// File: rtl/awrp_ram_chk.sv
module awrp_ram_chk
  import awrp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-3:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] raddr_q
);
  logic              prev_we;
  logic [ADDR_W-3:0] prev_waddr;
  logic [31:0]       prev_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we    <= 1'b0;
      prev_waddr <= '0;
      prev_wdata <= '0;
    end else begin
      prev_we    <= wr_en;
      prev_waddr <= wr_addr;
      prev_wdata <= wr_data;
    end
  end

  // R3: the captured address is the one presented at the previous edge
  a_r3_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> raddr_q == $past(rd_addr));

  // R6: no write and a held address keep the output byte still
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(raddr_q)) |-> $stable(rd_data));

  // R5: a write to the word under the captured address shows at once
  a_r5_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_we && prev_waddr == raddr_q[ADDR_W-1:LANE_W])
      |-> rd_data == prev_wdata[raddr_q[LANE_W-1:0]*BYTE_W +: BYTE_W]);

  // R7: reset holds the captured read address at zero
  a_r7_reset_addr: assert property (@(posedge clk)
    !rst_n |-> raddr_q == '0);
endmodule

bind awrp_ram awrp_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .raddr_q (raddr_q)
);

// File: tb/sim_awrp_ram.sv
module sim_awrp_ram;
  localparam int AW  = 8;
  localparam int WAW = AW - 2;
  localparam int NW  = 1 << WAW;
  localparam int NB  = 1 << AW;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b1;
  logic          wr_en;
  logic [WAW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [NW];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  awrp_ram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] lane_of(logic [31:0] w, int lane);
    return w[lane*8 +: 8];
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [WAW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[a] = d;
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, lane_of(mdl[a[AW-1:2]], int'(a[1:0])));
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 and R2: fill every word with a distinct pattern, sweep every byte
    for (int w = 0; w < NW; w++) begin
      d = {8'(w), 8'(~w), 8'(w ^ 8'h5A), 8'(w + 8'h33)};
      wr(WAW'(w), d);
    end
    for (int b = 0; b < NB; b++) rd(AW'(b), "R2 R8");

    // R1: pseudo-random overwrites in scattered order, then full sweep
    for (int i = 0; i < 3 * NW; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      d    = seed ^ {seed[15:0], seed[31:16]};
      wr(WAW'(seed[29:24]), d);
    end
    for (int b = 0; b < NB; b++) rd(AW'(b), "R1");

    // R3: mid-cycle address change has no effect until the next edge
    rd(8'h4E, "R3");
    rd_addr = 8'hB1;
    #2 chk("R3", rd_data, lane_of(mdl[6'h13], 2));
    @(negedge clk);
    chk("R3", rd_data, lane_of(mdl[6'h2C], 1));

    // R4: write under a held read address shows one cycle after the write edge
    rd({6'd5, 2'd2}, "R4");
    d = 32'hC0FF_EE42;
    wr_en = 1'b1; wr_addr = 6'd5; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; mdl[5] = d;
    chk("R4", rd_data, 8'hFF);

    // R5: read address and write to the same word on one edge, every lane
    for (int l = 0; l < 4; l++) begin
      d = 32'hA1B2_C3D4 + 32'(l * 32'h0101_0101);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd9; wr_data = d; rd_addr = {6'd9, 2'(l)};
      @(negedge clk);
      wr_en = 1'b0; mdl[9] = d;
      chk("R5", rd_data, lane_of(d, l));
    end

    // R6: wr_en low with live address and data leaves the word alone
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 6'd9; wr_data = ~mdl[9]; rd_addr = {6'd9, 2'd0};
    @(negedge clk);
    chk("R6", rd_data, lane_of(mdl[9], 0));
    for (int l = 0; l < 4; l++) rd({6'd9, 2'(l)}, "R6");

    // R7: reset forces address 0 and blocks writes
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b1; wr_addr = 6'd0; wr_data = ~mdl[0]; rd_addr = 8'h5D;
    #1 chk("R7", rd_data, lane_of(mdl[0], 0));
    @(negedge clk);
    chk("R7", rd_data, lane_of(mdl[0], 0));
    wr_en = 1'b0; rst_n = 1'b1;
    for (int l = 0; l < 4; l++) rd({6'd0, 2'(l)}, "R7");

    summary();
  end
endmodule